// File: doc/BRIEF.md
# Register Subtract Execute Unit with Status Flags

This block executes one instruction: a register-to-register subtraction. A 16-bit instruction word arrives with a valid strobe. When its low seven bits carry the subtract opcode, the unit does the following in a single clock edge:

- reads two operands from an internal file of eight 32-bit registers;
- forms the second-named source minus the first-named source;
- writes the difference to the destination register;
- refreshes three status bits in a 32-bit control/status register (CSR).

Every other word leaves all state alone.

Two external write paths let surrounding logic preload state. One loads a register of the file. The other replaces the whole CSR. A combinational read port exposes any register.

The carry flag holds the inverse of the borrow. Software can therefore chain it into wider subtractions: carry = 1 means "no borrow", and carry = 0 means subtract one more. The overflow flag serves signed operands and the carry flag serves unsigned operands. Both flags are produced on every subtract.

Top module: `subx_exec_unit`

## Requirements
- R1: After reset, all eight registers and the CSR read as zero.
- R2: The word is split into three register fields and an opcode:
  - destination in bits [15:13];
  - minuend register ("src2") in bits [12:10];
  - subtrahend register ("src1") in bits [9:7];
  - opcode in bits [6:0].
  
  When valid is high and the opcode is 7'b0110011, the destination holds (src2 − src1) mod 2^32 at the same clock edge.
- R3: On a subtract, CSR bit 2 becomes 1 if the difference is zero and 0 otherwise.
- R4: On a subtract, CSR bit 5 becomes 1 when src2 ≥ src1 as unsigned values (no borrow) and 0 when a borrow occurs.
- R5: On a subtract, CSR bit 7 becomes 1 exactly when the signed two's-complement difference does not fit in 32 bits.
- R6: A subtract leaves every CSR bit other than 2, 5 and 7 unchanged.
- R7: With valid low, or with any opcode other than 7'b0110011, no register and no CSR bit changes.
- R8: When the destination equals a source register, the operand is the value held before the edge, so rX = rX − rX gives 0 with bit 2 = 1 and bit 5 = 1.
- R9: When the external register write is enabled, the addressed register takes the write data at the clock edge. If a subtract targets the same register in the same cycle, the subtract result is stored.
- R10: When the CSR write is enabled, the CSR takes the write data at the clock edge. If a subtract happens in the same cycle, bits 2, 5 and 7 come from the subtract and all other bits come from the write data.
- R11: The read data port shows the register selected by the read address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| rf_rd_addr_i | input | 3 | Register read-port address |
| rf_rd_data_o | output | 32 | Register read-port data |
| rf_wr_en_i | input | 1 | External register write enable |
| rf_wr_addr_i | input | 3 | External register write address |
| rf_wr_data_i | input | 32 | External register write data |
| csr_wr_en_i | input | 1 | CSR write enable |
| csr_wr_data_i | input | 32 | CSR write data |
| csr_o | output | 32 | Current CSR value |

## Verification
A wrong field decode or swapped operand order shows up on the read port one edge after the instruction. It appears as a negated or wrongly addressed difference. A borrow or overflow computed the wrong way shows in bits 5 and 7 of the CSR output in that same cycle. It is exposed by operand pairs that sit on the unsigned and signed wrap points. A leak through the flag merge shows at once in the untouched CSR bits. A faulty opcode match shows as a register or flag that moves when it should hold. Collisions between the external write paths and an execute, and destination-equals-source cases, separate write priority and read-before-write order within one edge.

// File: rtl/subx_pkg.sv
package subx_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 7;
  localparam int FLD_W   = 3;

  localparam logic [OPC_W-1:0] OPC_SUB = 7'b0110011;

  localparam int EQ_BIT = 2;
  localparam int C_BIT  = 5;
  localparam int V_BIT  = 7;

  typedef struct packed {
    logic [FLD_W-1:0] dst;
    logic [FLD_W-1:0] src2;
    logic [FLD_W-1:0] src1;
    logic [OPC_W-1:0] opc;
  } instr_t;

  typedef struct packed {
    logic eq;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/subx_decode.sv
module subx_decode
  import subx_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [FLD_W-1:0]   dst_o,
  output logic [FLD_W-1:0]   src2_o,
  output logic [FLD_W-1:0]   src1_o,
  output logic               exec_o
);
  instr_t word;

  always_comb begin
    word   = instr_t'(instr_i);
    dst_o  = word.dst;
    src2_o = word.src2;
    src1_o = word.src1;
    exec_o = valid_i && (word.opc == OPC_SUB);
  end
endmodule

// File: rtl/subx_alu.sv
module subx_alu
  import subx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] minu_i,
  input  logic [DATA_W-1:0] subt_i,
  output logic [DATA_W-1:0] diff_o,
  output flags_t            flags_o
);
  localparam int EXT_W = DATA_W + 1;

  function automatic logic [EXT_W-1:0] f_wide_sub(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic f_signed_ovf(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [DATA_W-1:0] r);
    return (a[DATA_W-1] != b[DATA_W-1]) && (r[DATA_W-1] != a[DATA_W-1]);
  endfunction

  logic [EXT_W-1:0] wide;
  logic             borrow;

  always_comb begin
    wide       = f_wide_sub(minu_i, subt_i);
    borrow     = wide[DATA_W];
    diff_o     = wide[DATA_W-1:0];
    flags_o.eq = (diff_o == '0);
    flags_o.c  = !borrow;
    flags_o.v  = f_signed_ovf(minu_i, subt_i, diff_o);
  end
endmodule

// File: rtl/subx_regfile.sv
module subx_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ext_we_i,
  input  logic [AW-1:0]     ext_addr_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              exe_we_i,
  input  logic [AW-1:0]     exe_addr_i,
  input  logic [DATA_W-1:0] exe_data_i
);
  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(gi);
    logic hit_exe;
    logic hit_ext;

    assign hit_exe = exe_we_i && (exe_addr_i == IDX);
    assign hit_ext = ext_we_i && (ext_addr_i == IDX);

    always_ff @(posedge clk) begin
      if (!rst_n)       mem_q[gi] <= '0;
      else if (hit_exe) mem_q[gi] <= exe_data_i;
      else if (hit_ext) mem_q[gi] <= ext_data_i;
    end

    // R7: a register with no write request keeps its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(exe_we_i && exe_addr_i == IDX) && !(ext_we_i && ext_addr_i == IDX)
      |=> $stable(mem_q[gi]));

    // R2/R9: an execute write lands regardless of a colliding external write
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (exe_we_i && exe_addr_i == IDX) |=> (mem_q[gi] == $past(exe_data_i)));
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/subx_csr.sv
module subx_csr
  import subx_pkg::*;
#(
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we_i,
  input  logic [CSR_W-1:0] sw_data_i,
  input  logic             exe_we_i,
  input  flags_t           flags_i,
  output logic [CSR_W-1:0] csr_o
);
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] csr_d;

  always_comb begin
    csr_d = sw_we_i ? sw_data_i : csr_q;
    if (exe_we_i) begin
      csr_d[EQ_BIT] = flags_i.eq;
      csr_d[C_BIT]  = flags_i.c;
      csr_d[V_BIT]  = flags_i.v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  assign csr_o = csr_q;

  // R7: no write source, no change
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!exe_we_i && !sw_we_i) |=> $stable(csr_q));

  // R10: software value survives outside the flag bits when both write
  p_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_we_i && sw_we_i) |=> (csr_q[CSR_W-1:V_BIT+1] == $past(sw_data_i[CSR_W-1:V_BIT+1])));
endmodule

// File: rtl/subx_exec_unit.sv
module subx_exec_unit
  import subx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int CSR_W  = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AW-1:0]      rf_rd_addr_i,
  output logic [DATA_W-1:0]  rf_rd_data_o,
  input  logic               rf_wr_en_i,
  input  logic [AW-1:0]      rf_wr_addr_i,
  input  logic [DATA_W-1:0]  rf_wr_data_i,
  input  logic               csr_wr_en_i,
  input  logic [CSR_W-1:0]   csr_wr_data_i,
  output logic [CSR_W-1:0]   csr_o
);
  localparam logic [CSR_W-1:0] FLAG_MASK =
    (CSR_W'(1) << EQ_BIT) | (CSR_W'(1) << C_BIT) | (CSR_W'(1) << V_BIT);

  // named internal events for the checks below
  logic [FLD_W-1:0]  dst_sel;
  logic [FLD_W-1:0]  src2_sel;
  logic [FLD_W-1:0]  src1_sel;
  logic              exec_fire;
  logic [DATA_W-1:0] op_minu;
  logic [DATA_W-1:0] op_subt;
  logic [DATA_W-1:0] diff;
  flags_t            flags;

  subx_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .dst_o   (dst_sel),
    .src2_o  (src2_sel),
    .src1_o  (src1_sel),
    .exec_o  (exec_fire)
  );

  subx_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_addr_i  (AW'(src2_sel)),
    .ra_data_o  (op_minu),
    .rb_addr_i  (AW'(src1_sel)),
    .rb_data_o  (op_subt),
    .rd_addr_i  (rf_rd_addr_i),
    .rd_data_o  (rf_rd_data_o),
    .ext_we_i   (rf_wr_en_i),
    .ext_addr_i (rf_wr_addr_i),
    .ext_data_i (rf_wr_data_i),
    .exe_we_i   (exec_fire),
    .exe_addr_i (AW'(dst_sel)),
    .exe_data_i (diff)
  );

  subx_alu #(.DATA_W(DATA_W)) u_alu (
    .minu_i  (op_minu),
    .subt_i  (op_subt),
    .diff_o  (diff),
    .flags_o (flags)
  );

  subx_csr #(.CSR_W(CSR_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we_i   (csr_wr_en_i),
    .sw_data_i (csr_wr_data_i),
    .exe_we_i  (exec_fire),
    .flags_i   (flags),
    .csr_o     (csr_o)
  );

  // R3: zero flag follows operand equality
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (csr_o[EQ_BIT] == ($past(op_minu) == $past(op_subt))));

  // R4: carry set exactly when no unsigned borrow
  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (csr_o[C_BIT] == ($past(op_minu) >= $past(op_subt))));

  // R5: like-signed operands never overflow on subtraction
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && (op_minu[DATA_W-1] == op_subt[DATA_W-1])) |=> !csr_o[V_BIT]);

  // R6: non-flag bits kept across a subtract without software write
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !csr_wr_en_i) |=> ((csr_o & ~FLAG_MASK) == $past(csr_o & ~FLAG_MASK)));
endmodule

// File: tb/tb_subx_exec_unit.sv
module tb_subx_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [2:0]  rf_rd_addr_i = '0;
  logic [31:0] rf_rd_data_o;
  logic        rf_wr_en_i = 1'b0;
  logic [2:0]  rf_wr_addr_i = '0;
  logic [31:0] rf_wr_data_i = '0;
  logic        csr_wr_en_i = 1'b0;
  logic [31:0] csr_wr_data_i = '0;
  logic [31:0] csr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_reg [8];
  logic [31:0] m_csr;

  always #10 clk = ~clk;

  subx_exec_unit dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .rf_rd_addr_i(rf_rd_addr_i), .rf_rd_data_o(rf_rd_data_o),
    .rf_wr_en_i(rf_wr_en_i), .rf_wr_addr_i(rf_wr_addr_i), .rf_wr_data_i(rf_wr_data_i),
    .csr_wr_en_i(csr_wr_en_i), .csr_wr_data_i(csr_wr_data_i), .csr_o(csr_o)
  );

  function automatic logic [15:0] enc(input logic [2:0] d, input logic [2:0] s2,
                                      input logic [2:0] s1, input logic [6:0] op);
    return {d, s2, s1, op};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input string tag, input int idx);
    rf_rd_addr_i = 3'(idx);
    #1;
    check(tag, rf_rd_data_o, m_reg[idx]);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) check_reg(tag, i);
    check(tag, csr_o, m_csr);
  endtask

  // expected result of a subtract on the model, computed arithmetically
  task automatic model_sub(input int d, input int s2, input int s1);
    logic [31:0] a, b, r;
    logic [32:0] w;
    longint sd;
    a  = m_reg[s2];
    b  = m_reg[s1];
    w  = {1'b0, a} - {1'b0, b};
    r  = w[31:0];
    sd = longint'($signed(a)) - longint'($signed(b));
    m_reg[d]  = r;
    m_csr[2]  = (a == b);
    m_csr[5]  = (a >= b);
    m_csr[7]  = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
  endtask

  // one edge with every input set; strobes dropped afterwards
  task automatic step(input logic v, input logic [15:0] ins,
                      input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic cwe, input logic [31:0] cwd);
    @(negedge clk);
    instr_valid_i = v; instr_i = ins;
    rf_wr_en_i = we; rf_wr_addr_i = wa; rf_wr_data_i = wd;
    csr_wr_en_i = cwe; csr_wr_data_i = cwd;
    @(negedge clk);
    instr_valid_i = 1'b0; rf_wr_en_i = 1'b0; csr_wr_en_i = 1'b0;
  endtask

  task automatic load(input int idx, input logic [31:0] val);
    step(1'b0, '0, 1'b1, 3'(idx), val, 1'b0, '0);
    m_reg[idx] = val;
  endtask

  task automatic do_sub(input string tag, input int d, input int s2, input int s1);
    model_sub(d, s2, s1);
    step(1'b1, enc(3'(d), 3'(s2), 3'(s1), 7'b0110011), 1'b0, '0, '0, 1'b0, '0);
    check_reg({tag, " dst"}, d);
    check({tag, " csr"}, csr_o, m_csr);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_csr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
  endtask

  task automatic t_load;
    load(1, 32'd10); load(2, 32'd3); load(5, 32'h8000_0000); load(6, 32'd1);
    check_reg("R9 ext write", 1);
    check_reg("R11 read port", 5);
  endtask

  task automatic t_basic;
    do_sub("R2 R4 basic", 3, 1, 2);
    check("R4 no borrow", {31'b0, csr_o[5]}, 32'd1);
    do_sub("R2 R4 order", 4, 2, 1);
    check("R2 order value", rf_rd_data_o, 32'hFFFF_FFF9);
    check("R4 borrow", {31'b0, csr_o[5]}, 32'd0);
  endtask

  task automatic t_zero;
    load(7, 32'd10);
    do_sub("R3 equal", 0, 7, 1);
    check("R3 zero flag", {31'b0, csr_o[2]}, 32'd1);
  endtask

  task automatic t_overflow;
    do_sub("R5 min minus one", 3, 5, 6);
    check("R5 value", rf_rd_data_o, 32'h7FFF_FFFF);
    check("R5 flag", {31'b0, csr_o[7]}, 32'd1);
    load(2, 32'h7FFF_FFFF); load(4, 32'hFFFF_FFFF);
    do_sub("R5 max minus neg", 0, 2, 4);
    check("R5 flag2", {31'b0, csr_o[7]}, 32'd1);
    do_sub("R5 no ovf", 0, 4, 6);
    check("R5 clear", {31'b0, csr_o[7]}, 32'd0);
  endtask

  task automatic t_keep;
    step(1'b0, '0, 1'b0, '0, '0, 1'b1, 32'hA5A5_FF5B);
    m_csr = 32'hA5A5_FF5B;
    check("R10 csr write", csr_o, m_csr);
    do_sub("R6 keep bits", 3, 1, 2);
    check("R6 upper", csr_o & ~32'h0000_00A4, 32'hA5A5_FF5B & ~32'h0000_00A4);
  endtask

  task automatic t_ignore;
    step(1'b1, enc(3'd0, 3'd1, 3'd2, 7'b0110010), 1'b0, '0, '0, 1'b0, '0);
    check_all("R7 bad opcode");
    step(1'b1, enc(3'd0, 3'd1, 3'd2, 7'b1110011), 1'b0, '0, '0, 1'b0, '0);
    check_all("R7 bad opcode msb");
    step(1'b0, enc(3'd0, 3'd1, 3'd2, 7'b0110011), 1'b0, '0, '0, 1'b0, '0);
    check_all("R7 valid low");
  endtask

  task automatic t_alias;
    load(4, 32'd50); load(5, 32'd8);
    do_sub("R8 dst is src2", 4, 4, 5);
    check("R8 value", rf_rd_data_o, 32'd42);
    do_sub("R8 dst is src1", 5, 4, 5);
    check("R8 value2", rf_rd_data_o, 32'd34);
    do_sub("R8 all same", 6, 6, 6);
    check("R8 eq", {29'b0, csr_o[5], 1'b0, csr_o[2]}, 32'd5);
  endtask

  task automatic t_collide;
    model_sub(3, 1, 2);
    step(1'b1, enc(3'd3, 3'd1, 3'd2, 7'b0110011), 1'b1, 3'd3, 32'hDEAD_BEEF, 1'b0, '0);
    check_reg("R9 exec wins", 3);
    model_sub(0, 2, 1);
    step(1'b1, enc(3'd0, 3'd2, 3'd1, 7'b0110011), 1'b1, 3'd7, 32'h1234_5678, 1'b0, '0);
    m_reg[7] = 32'h1234_5678;
    check_reg("R9 other reg", 7);
    check_reg("R9 dst", 0);
    model_sub(1, 1, 1);
    step(1'b1, enc(3'd1, 3'd1, 3'd1, 7'b0110011), 1'b0, '0, '0, 1'b1, 32'h0F0F_0000);
    m_csr = (32'h0F0F_0000 & ~32'h0000_00A4) | (m_csr & 32'h0000_00A4);
    check("R10 merge", csr_o, m_csr);
    check_reg("R10 dst", 1);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_load();
    t_basic();
    t_zero();
    t_overflow();
    t_keep();
    t_ignore();
    t_alias();
    t_collide();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule